// File: doc/BRIEF.md
# Keyed-Lock Priority Arbiter for a Shared Memory Port

This block decides, every clock cycle, which of four requesters may use a single shared memory port. The requesters are, in fixed index order, the main program (index 0), the interrupt handler (index 1), a DMA channel (index 2) and a scanner (index 3). Each requester has its own 3-bit priority register, and the requester with the lowest number wins. When two or more priorities are equal, the lower index wins.

Software programs the priorities through a simple register write port. A lock bit guards the priority registers. The lock bit itself changes only after a two-byte key has been written to the lock register, so a stray write cannot reorder the memory traffic while the system runs.

The grant is combinational. It follows the current request vector and the stored priorities within the same cycle. Register writes take effect at the clock edge on which they are sampled.

Top module: `mem_port_arbiter`

## Requirements
- R1: Among the active requests, the grant goes to the requester whose priority register holds the smallest value, where 0 is the most urgent and 7 the least urgent.
- R2: After reset, every priority register holds 7 and the lock bit reads 0, which means unlocked.
- R3: When the smallest active priority value is shared by several requesters, the one with the lowest index wins. The index order is main (0), interrupt (1), DMA (2), scanner (3).
- R4: The lock bit changes only in a fixed sequence. First, 0x55 is written to the lock register at address 4. The very next write must be 0xAA to that same address. The write after that, if it goes to address 4, sets the lock bit to bit 0 of its data.
- R5: Setting the lock bit again, or clearing it, needs the same key. A write to address 4 without the preceding 0x55/0xAA pair leaves the lock bit unchanged.
- R6: A write to priority register i (addresses 0 to 3, data bits 2:0) is accepted only while the lock bit is 0. While the lock bit is 1, such writes leave the register unchanged.
- R7: Any write that does not continue the key sequence returns the key detector to idle. The only exception is a 0x55 written to address 4, which starts a new sequence.
- R8: Whenever at least one request is active, exactly one grant bit is high.
- R9: No grant bit is high without its request, and with no requests the grant is all zero. The grant responds in the same cycle as the requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NUM_REQ | Request per requester; bit 0 is main, bit 3 is scanner |
| grant | output | NUM_REQ | One-hot grant, combinational |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 to 3 select priority registers, 4 selects the lock register |
| wr_data | input | DATA_W | Write data |
| locked | output | 1 | Current lock bit |

## Verification
The bench builds the block with its defaults: four requesters, 3-bit priorities and 8-bit write data. With these values both extreme priorities, 0 and 7, can be reached, as can multi-way ties at any level. With only four requesters, every ordering of interest fits in a short vector table. The 8-bit data width lets the bench drive the exact key bytes, as well as near-miss sequences: an interrupted key, a repeated first byte, and a lock write with no key in front of it.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } key_state_e;
endpackage

// File: rtl/key_lock.sv
module key_lock
  import arb_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  KEY_FIRST = 8'h55,
  parameter logic [7:0]  KEY_NEXT  = 8'hAA,
  parameter logic        LOCK_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_is_lock,
  input  logic [DATA_W-1:0] wr_data,
  output logic              locked,
  output logic              key_commit
);
  key_state_e state_q, state_n;
  logic       lock_q;
  logic       hit_first, hit_next;

  assign hit_first  = wr_en && wr_is_lock && (wr_data[7:0] == KEY_FIRST);
  assign hit_next   = wr_en && wr_is_lock && (wr_data[7:0] == KEY_NEXT);
  assign key_commit = (state_q == KEY_OPEN) && wr_en && wr_is_lock;

  always_comb begin
    state_n = state_q;
    if (wr_en) begin
      unique case (state_q)
        KEY_IDLE: state_n = hit_first ? KEY_HALF : KEY_IDLE;
        KEY_HALF: state_n = hit_next ? KEY_OPEN : (hit_first ? KEY_HALF : KEY_IDLE);
        KEY_OPEN: state_n = KEY_IDLE;
        default:  state_n = KEY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KEY_IDLE;
      lock_q  <= LOCK_INIT;
    end else begin
      state_q <= state_n;
      if (key_commit) lock_q <= wr_data[0];
    end
  end

  assign locked = lock_q;

  // R4/R5: the lock bit moves only on a write completing the key
  a_r4_lock_moves_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != $past(lock_q)) |-> $past(key_commit));

  // R7: a write that neither continues nor restarts the key drops to idle
  a_r7_break_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KEY_HALF && wr_en && !hit_first && !hit_next) |=> (state_q == KEY_IDLE));
endmodule

// File: rtl/prio_regs.sv
module prio_regs #(
  parameter int NUM_REQ = 4,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      locked,
  output logic [NUM_REQ*PRIO_W-1:0] prio_flat
);
  localparam logic [PRIO_W-1:0] PRIO_LOWEST = '1;

  logic [NUM_REQ-1:0] reg_hit;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_prio
    logic [PRIO_W-1:0] val_q;
    assign reg_hit[i] = wr_en && !locked && (wr_addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          val_q <= PRIO_LOWEST;
      else if (reg_hit[i]) val_q <= wr_data[PRIO_W-1:0];
    end
    assign prio_flat[i*PRIO_W +: PRIO_W] = val_q;
  end

  // R6: while locked, no priority register can change
  a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(prio_flat));
endmodule

// File: rtl/prio_select.sv
module prio_select #(
  parameter int NUM_REQ = 4,
  parameter int PRIO_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        req,
  input  logic [NUM_REQ*PRIO_W-1:0] prio_flat,
  output logic [NUM_REQ-1:0]        grant
);
  // Scan in index order; a strict less-than keeps the earlier index on ties.
  function automatic logic [NUM_REQ-1:0] pick_winner(
    input logic [NUM_REQ-1:0]        r,
    input logic [NUM_REQ*PRIO_W-1:0] p
  );
    logic              found;
    logic [PRIO_W-1:0] best;
    pick_winner = '0;
    found       = 1'b0;
    best        = '1;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (r[i] && (!found || (p[i*PRIO_W +: PRIO_W] < best))) begin
        found          = 1'b1;
        best           = p[i*PRIO_W +: PRIO_W];
        pick_winner    = '0;
        pick_winner[i] = 1'b1;
      end
    end
  endfunction

  assign grant = pick_winner(req, prio_flat);

  // R8: a single winner whenever anyone asks
  a_r8_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ($countones(grant) == 1));

  // R9: never grant a requester that is not asking
  a_r9_no_orphan_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter #(
  parameter  int NUM_REQ = 4,
  parameter  int PRIO_W  = 3,
  parameter  int DATA_W  = 8,
  localparam int ADDR_W  = $clog2(NUM_REQ + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] grant,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               locked
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(NUM_REQ);

  logic                      wr_is_lock;
  logic                      key_commit;
  logic [NUM_REQ*PRIO_W-1:0] prio_flat;

  assign wr_is_lock = (wr_addr == LOCK_ADDR);

  key_lock #(.DATA_W(DATA_W)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_lock(wr_is_lock),
    .wr_data(wr_data), .locked(locked), .key_commit(key_commit)
  );

  prio_regs #(.NUM_REQ(NUM_REQ), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .locked(locked), .prio_flat(prio_flat)
  );

  prio_select #(.NUM_REQ(NUM_REQ), .PRIO_W(PRIO_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .req(req), .prio_flat(prio_flat), .grant(grant)
  );

  // R4: a lock change always lands on a write to the lock register
  a_r4_change_on_lock_write: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |-> $past(wr_en && wr_is_lock && key_commit));
endmodule

// File: tb/mem_port_arbiter_bench.sv
`timescale 1ns/1ps
module mem_port_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] grant;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       locked;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mem_port_arbiter u_mem_port_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .locked(locked)
  );

  // {p3, p2, p1, p0, req, expected grant}; bit 0 = main ... bit 3 = scanner
  localparam logic [19:0] VEC [10] = '{
    {3'd7, 3'd7, 3'd7, 3'd7, 4'b1111, 4'b0001},
    {3'd7, 3'd7, 3'd7, 3'd7, 4'b1110, 4'b0010},
    {3'd0, 3'd2, 3'd1, 3'd3, 4'b1111, 4'b1000},
    {3'd0, 3'd2, 3'd1, 3'd3, 4'b0111, 4'b0010},
    {3'd0, 3'd2, 3'd1, 3'd3, 4'b0101, 4'b0100},
    {3'd5, 3'd5, 3'd0, 3'd0, 4'b1100, 4'b0100},
    {3'd6, 3'd2, 3'd2, 3'd5, 4'b1111, 4'b0010},
    {3'd6, 3'd2, 3'd2, 3'd5, 4'b0000, 4'b0000},
    {3'd7, 3'd7, 3'd7, 3'd0, 4'b1110, 4'b0010},
    {3'd0, 3'd7, 3'd7, 3'd7, 4'b0111, 4'b0001}
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic grant_for(input logic [3:0] r, input logic [3:0] exp, input string tag);
    @(negedge clk);
    req = r;
    #1;
    check(tag, grant, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    check("R2 lock after reset", {3'b0, locked}, 4'b0000);
    grant_for(4'b1111, 4'b0001, "R2 equal reset priorities, R3 order");
    wr(3'd1, 8'd6);
    grant_for(4'b0011, 4'b0010, "R2 main still lowest (7) vs 6");

    // R1/R3/R8/R9 vector table
    for (int v = 0; v < 10; v++) begin
      wr(3'd0, {5'b0, VEC[v][10:8]});
      wr(3'd1, {5'b0, VEC[v][13:11]});
      wr(3'd2, {5'b0, VEC[v][16:14]});
      wr(3'd3, {5'b0, VEC[v][19:17]});
      grant_for(VEC[v][7:4], VEC[v][3:0], $sformatf("R1/R3/R8/R9 vector %0d", v));
    end

    wr(3'd0, 8'd1);
    wr(3'd3, 8'd2);
    // R5: lock write without the key has no effect
    wr(3'd4, 8'h01);
    check("R5 unkeyed lock write", {3'b0, locked}, 4'b0000);
    // R4: full key then lock
    wr(3'd4, 8'h55); wr(3'd4, 8'hAA); wr(3'd4, 8'h01);
    check("R4 keyed lock", {3'b0, locked}, 4'b0001);
    // R6: locked write ignored
    wr(3'd3, 8'd0);
    grant_for(4'b1001, 4'b0001, "R6 locked priority write ignored");
    // R7: a broken sequence does not unlock
    wr(3'd4, 8'h55); wr(3'd3, 8'd0); wr(3'd4, 8'hAA); wr(3'd4, 8'h00);
    check("R7 broken key keeps lock", {3'b0, locked}, 4'b0001);
    grant_for(4'b1001, 4'b0001, "R6 write inside broken key ignored");
    // R7: repeated first byte restarts the sequence
    wr(3'd4, 8'h55); wr(3'd4, 8'h55); wr(3'd4, 8'hAA); wr(3'd4, 8'h00);
    check("R7 restart then unlock", {3'b0, locked}, 4'b0000);
    // R6: unlocked write now accepted
    wr(3'd3, 8'd0);
    grant_for(4'b1001, 4'b1000, "R6 unlocked priority write taken");
    // R5: key again re-locks
    wr(3'd4, 8'h55); wr(3'd4, 8'hAA); wr(3'd4, 8'h01);
    check("R5 keyed relock", {3'b0, locked}, 4'b0001);
    grant_for(4'b0000, 4'b0000, "R9 no requests no grant");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule